// File: doc/BRIEF.md
# Long-Result Multiply-Accumulate Datapath

This block multiplies two 32-bit operands under one of six operations. The short forms keep only the low word of the product, and can add a 32-bit addend to it. The long forms return the full 64-bit product as a high word and a low word. They treat the operands as either unsigned or two's complement, and can add a 64-bit addend that is built from a high input word and a low input word. Alongside the result the block reports a negative flag and a zero flag.

The caller presents the operands, the addends and a 3-bit operation code, and pulses `start_i` while `busy_o` is low. All of these inputs are captured on that edge. The result appears with a one-cycle `done_o` pulse a fixed three clock edges later, and it stays on the outputs until the next completion. A new start may be issued in the same cycle that `done_o` is high.

Top module: `mac_long_unit`

## Requirements
- R1: Operation code 0 returns the low 32 bits of a_i*b_i on res_lo_o, with res_hi_o equal to zero.
- R2: Operation code 1 returns (a_i*b_i + acc_lo_i) modulo 2^32 on res_lo_o, with res_hi_o equal to zero.
- R3: Operation code 2 returns the full 64-bit product of the zero-extended operands, with bits 63:32 on res_hi_o and bits 31:0 on res_lo_o.
- R4: Operation code 3 returns the code-2 product plus {acc_hi_i, acc_lo_i}, wrapping modulo 2^64.
- R5: Operation code 4 returns the 64-bit product of the operands read as two's complement numbers.
- R6: Operation code 5 returns the code-4 product plus {acc_hi_i, acc_lo_i}, wrapping modulo 2^64.
- R7: Operation codes 6 and 7 behave exactly like code 0.
- R8: neg_o equals bit 31 of the result for codes 0, 1, 6 and 7, and bit 63 of {res_hi_o,res_lo_o} for codes 2 to 5.
- R9: zero_o is high exactly when the whole returned result (32 bits for the short forms, 64 bits for the long forms) is zero.
- R10: A start sampled while busy_o is low produces a done_o pulse that is high for exactly one cycle, three rising edges later. busy_o is high for the two cycles in between.
- R11: start_i and every data input are ignored while busy_o is high, and after the capture edge. The result and flags hold their values from one done_o pulse until the next.
- R12: While reset is active and after it is released, busy_o, done_o, both result words and both flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a new operation |
| op_i | input | 3 | Operation code |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| acc_hi_i | input | 32 | Addend high word (long accumulate only) |
| acc_lo_i | input | 32 | Addend low word |
| busy_o | output | 1 | Operation in flight, start ignored |
| done_o | output | 1 | Result valid pulse |
| res_hi_o | output | 32 | Result high word |
| res_lo_o | output | 32 | Result low word |
| neg_o | output | 1 | Result negative |
| zero_o | output | 1 | Result zero |

## Verification
The bench targets operands at the sign boundary, such as all-ones times all-ones and the most negative value times one. Treating these as signed when they should be unsigned, or the reverse, changes the high word. Accumulates that carry out of the low word into the high word would expose a design that adds the halves separately. Accumulates that wrap past 2^64 or 2^32 to exactly zero would expose a design that takes the flags from the wrong width. Starts with different operands are driven while the unit is busy: a design that recaptured them would return the wrong product. It would also shift or repeat the done pulse. Codes 6 and 7 are driven against a design that might decode them as long forms.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [2:0] {
    OP_MUL   = 3'd0,
    OP_MLA   = 3'd1,
    OP_UMULL = 3'd2,
    OP_UMLAL = 3'd3,
    OP_SMULL = 3'd4,
    OP_SMLAL = 3'd5
  } op_e;

  typedef struct packed {
    logic is_long;
    logic is_signed;
    logic do_acc;
  } ctl_t;
endpackage

// File: rtl/mac_op_decode.sv
module mac_op_decode
  import mac_pkg::*;
(
  input  logic [2:0] op_i,
  output ctl_t       ctl_o
);
  always_comb begin
    ctl_o = '0;
    unique case (op_i)
      OP_MLA:   ctl_o = '{is_long: 1'b0, is_signed: 1'b0, do_acc: 1'b1};
      OP_UMULL: ctl_o = '{is_long: 1'b1, is_signed: 1'b0, do_acc: 1'b0};
      OP_UMLAL: ctl_o = '{is_long: 1'b1, is_signed: 1'b0, do_acc: 1'b1};
      OP_SMULL: ctl_o = '{is_long: 1'b1, is_signed: 1'b1, do_acc: 1'b0};
      OP_SMLAL: ctl_o = '{is_long: 1'b1, is_signed: 1'b1, do_acc: 1'b1};
      default:  ctl_o = '0; // plain multiply, including unused codes
    endcase
  end
endmodule

// File: rtl/mac_mul_core.sv
module mac_mul_core #(
  parameter int W = 32,
  localparam int DW = 2 * W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  input  logic          sgn_i,
  output logic [DW-1:0] prod_o
);
  logic [W-1:0] opnd [2];
  logic [W:0]   ext  [2];

  assign opnd[0] = a_i;
  assign opnd[1] = b_i;

  // one extra top bit: sign copy for signed, zero for unsigned
  for (genvar i = 0; i < 2; i++) begin : g_ext
    assign ext[i] = {sgn_i & opnd[i][W-1], opnd[i]};
  end

  logic signed [DW-1:0] full;
  assign full = DW'($signed(ext[0])) * DW'($signed(ext[1]));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   prod_o <= '0;
    else if (en_i) prod_o <= full;
  end
endmodule

// File: rtl/mac_acc_stage.sv
module mac_acc_stage
  import mac_pkg::*;
#(
  parameter int W = 32,
  localparam int DW = 2 * W
) (
  input  logic [DW-1:0] prod_i,
  input  logic [DW-1:0] acc_i,
  input  ctl_t          ctl_i,
  output logic [DW-1:0] res_o,
  output logic          neg_o,
  output logic          zero_o
);
  logic [DW-1:0] sum;

  assign sum = prod_i + (ctl_i.do_acc ? acc_i : '0);

  always_comb begin
    if (ctl_i.is_long) begin
      res_o = sum;
      neg_o = sum[DW-1];
    end else begin
      res_o = {{W{1'b0}}, sum[W-1:0]};
      neg_o = sum[W-1];
    end
  end

  assign zero_o = (res_o == '0);
endmodule

// File: rtl/mac_long_unit.sv
module mac_long_unit
  import mac_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [2:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] acc_hi_i,
  input  logic [W-1:0] acc_lo_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] res_hi_o,
  output logic [W-1:0] res_lo_o,
  output logic         neg_o,
  output logic         zero_o
);
  localparam int DW = 2 * W;

  ctl_t dec_ctl;
  mac_op_decode u_dec (.op_i(op_i), .ctl_o(dec_ctl));

  // stage 1: operand capture
  logic          s1_v;
  logic [W-1:0]  a_q, b_q;
  logic [DW-1:0] acc1_q;
  ctl_t          ctl1_q;
  logic          accept;

  assign accept = start_i & ~busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v   <= 1'b0;
      a_q    <= '0;
      b_q    <= '0;
      acc1_q <= '0;
      ctl1_q <= '0;
    end else begin
      s1_v <= accept;
      if (accept) begin
        a_q    <= a_i;
        b_q    <= b_i;
        acc1_q <= dec_ctl.is_long ? {acc_hi_i, acc_lo_i} : {{W{1'b0}}, acc_lo_i};
        ctl1_q <= dec_ctl;
      end
    end
  end

  // stage 2: product
  logic [DW-1:0] prod;
  logic          s2_v;
  logic [DW-1:0] acc2_q;
  ctl_t          ctl2_q;

  mac_mul_core #(.W(W)) u_mul (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (s1_v),
    .a_i    (a_q),
    .b_i    (b_q),
    .sgn_i  (ctl1_q.is_signed),
    .prod_o (prod)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_v   <= 1'b0;
      acc2_q <= '0;
      ctl2_q <= '0;
    end else begin
      s2_v <= s1_v;
      if (s1_v) begin
        acc2_q <= acc1_q;
        ctl2_q <= ctl1_q;
      end
    end
  end

  // stage 3: accumulate, flags, result register
  logic [DW-1:0] res_d;
  logic          neg_d, zero_d;

  mac_acc_stage #(.W(W)) u_acc (
    .prod_i (prod),
    .acc_i  (acc2_q),
    .ctl_i  (ctl2_q),
    .res_o  (res_d),
    .neg_o  (neg_d),
    .zero_o (zero_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o   <= 1'b0;
      res_hi_o <= '0;
      res_lo_o <= '0;
      neg_o    <= 1'b0;
      zero_o   <= 1'b0;
    end else begin
      done_o <= s2_v;
      if (s2_v) begin
        res_hi_o <= res_d[DW-1:W];
        res_lo_o <= res_d[W-1:0];
        neg_o    <= neg_d;
        zero_o   <= zero_d;
      end
    end
  end

  assign busy_o = s1_v | s2_v;
endmodule

// File: rtl/mac_long_unit_chk.sv
module mac_long_unit_chk #(
  parameter int W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic [2:0]   op_i,
  input logic         busy_o,
  input logic         done_o,
  input logic [W-1:0] res_hi_o,
  input logic [W-1:0] res_lo_o,
  input logic         neg_o,
  input logic         zero_o
);
  // independent record of whether each in-flight op is a long form
  logic [2:0] long_sr;
  logic       take;
  assign take = start_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) long_sr <= '0;
    else         long_sr <= {long_sr[1:0], (op_i >= 3'd2) && (op_i <= 3'd5)};
  end

  a_r10_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |-> ##3 done_o);
  a_r10_busy_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> busy_o);
  a_r10_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(res_hi_o) && $stable(res_lo_o) && $stable(neg_o) && $stable(zero_o)));
  a_r1_short_hi_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !long_sr[2]) |-> (res_hi_o == '0));
  a_r8_neg_short: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !long_sr[2]) |-> (neg_o == res_lo_o[W-1]));
  a_r8_neg_long: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && long_sr[2]) |-> (neg_o == res_hi_o[W-1]));
  a_r9_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (zero_o == ((res_hi_o == '0) && (res_lo_o == '0))));
  a_r12_reset: assert property (@(posedge clk_i)
    !rst_ni |-> (!busy_o && !done_o && !neg_o && !zero_o));
endmodule

bind mac_long_unit mac_long_unit_chk #(.W(W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .op_i     (op_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .res_hi_o (res_hi_o),
  .res_lo_o (res_lo_o),
  .neg_o    (neg_o),
  .zero_o   (zero_o)
);

// File: tb/mac_long_unit_test.sv
module mac_long_unit_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [31:0] a_i = '0, b_i = '0, acc_hi_i = '0, acc_lo_i = '0;
  logic        busy_o, done_o, neg_o, zero_o;
  logic [31:0] res_hi_o, res_lo_o;

  int total = 0;
  int bad = 0;

  mac_long_unit uut (.*);

  always #5 clk_i = ~clk_i;

  function automatic logic [63:0] ref_res(input logic [2:0] op, input logic [31:0] a, b, hi, lo);
    logic [63:0] ea, eb, p;
    case (op)
      3'd2, 3'd3: begin ea = {32'd0, a}; eb = {32'd0, b}; end
      3'd4, 3'd5: begin ea = {{32{a[31]}}, a}; eb = {{32{b[31]}}, b}; end
      default:    begin ea = {32'd0, a}; eb = {32'd0, b}; end
    endcase
    p = ea * eb;
    if (op == 3'd3 || op == 3'd5) p = p + {hi, lo};
    if (op == 3'd1) p = {32'd0, p[31:0] + lo};
    else if (op < 3'd2 || op > 3'd5) p = {32'd0, p[31:0]};
    return p;
  endfunction

  function automatic string rtag(input logic [2:0] op);
    case (op)
      3'd0: return "R1"; 3'd1: return "R2"; 3'd2: return "R3";
      3'd3: return "R4"; 3'd4: return "R5"; 3'd5: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(input string req, input logic [63:0] act, exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one operation; garbage starts while busy must be ignored (R11)
  task automatic run_op(input logic [2:0] op, input logic [31:0] a, b, hi, lo);
    logic [63:0] exp;
    logic        lng;
    exp = ref_res(op, a, b, hi, lo);
    lng = (op >= 3'd2 && op <= 3'd5);
    @(negedge clk_i);
    op_i = op; a_i = a; b_i = b; acc_hi_i = hi; acc_lo_i = lo; start_i = 1'b1;
    @(negedge clk_i);
    chk("R10 busy c1", {62'd0, busy_o, done_o}, 64'd2);
    op_i = ~op; a_i = ~a; b_i = b + 32'd7; acc_hi_i = ~hi; acc_lo_i = lo ^ 32'h5a5a;
    @(negedge clk_i);
    chk("R10 busy c2", {62'd0, busy_o, done_o}, 64'd2);
    start_i = 1'b0;
    @(negedge clk_i);
    chk("R10 done", {62'd0, busy_o, done_o}, 64'd1);
    chk(rtag(op), {res_hi_o, res_lo_o}, exp);
    chk("R8", {63'd0, neg_o}, {63'd0, lng ? exp[63] : exp[31]});
    chk("R9", {63'd0, zero_o}, {63'd0, lng ? (exp == 64'd0) : (exp[31:0] == 32'd0)});
    @(negedge clk_i);
    chk("R11 hold", {done_o, neg_o, zero_o, res_hi_o[28:0], res_lo_o},
        {1'b0, lng ? exp[63] : exp[31], lng ? (exp == 64'd0) : (exp[31:0] == 32'd0),
         exp[60:32], exp[31:0]});
  endtask

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd1234);
    repeat (3) @(negedge clk_i);
    chk("R12 reset", {busy_o, done_o, neg_o, zero_o, res_hi_o, res_lo_o}, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R12 after release", {busy_o, done_o, neg_o, zero_o, res_hi_o, res_lo_o}, 64'd0);

    run_op(3'd0, 32'hffff_ffff, 32'hffff_ffff, 32'h0, 32'h0);          // R1
    run_op(3'd1, 32'h0001_0000, 32'h0001_0000, 32'h0, 32'h0);          // R2 wrap to 0
    run_op(3'd1, 32'h7fff_ffff, 32'd1, 32'h0, 32'd1);                  // R2 neg
    run_op(3'd2, 32'hffff_ffff, 32'hffff_ffff, 32'h0, 32'h0);          // R3
    run_op(3'd3, 32'hffff_ffff, 32'd1, 32'h0, 32'd1);                  // R4 carry
    run_op(3'd3, 32'hffff_ffff, 32'd1, 32'hffff_ffff, 32'd1);          // R4 wraps to 0
    run_op(3'd4, 32'hffff_ffff, 32'hffff_ffff, 32'h0, 32'h0);          // R5
    run_op(3'd4, 32'h8000_0000, 32'd1, 32'h0, 32'h0);                  // R5 neg
    run_op(3'd5, 32'hffff_ffff, 32'd1, 32'h0, 32'd1);                  // R6 to zero
    run_op(3'd6, 32'h1234_5678, 32'h9abc_def0, 32'hffff, 32'h1);       // R7
    run_op(3'd7, 32'h8000_0001, 32'h8000_0001, 32'hffff, 32'h1);       // R7
    run_op(3'd2, 32'h0, 32'h1234, 32'h0, 32'h0);                       // R9 zero

    for (int i = 0; i < 300; i++) begin
      run_op(3'($urandom_range(0, 7)), $urandom, $urandom, $urandom, $urandom);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule